// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-stage register that can be filled in two ways: all stages at once from a parallel byte, or one bit at a time from a serial input. Only the last stage is visible, as a single serial output. A mode input selects between the two ways of filling. The load or shift happens on an advance event. An advance event is made by two qualifying inputs whose OR acts as a combined clock. A rising edge on either input advances the register, but only while the other input is low. Holding one input high therefore inhibits the other.

The block runs on a single system clock and never gates it. The two qualifying inputs are synchronised and edge-detected, which gives a one-cycle advance strobe. The parallel inputs, serial input and mode are sampled on that strobe. A separate active-low clear empties every stage at once, with no clock needed. A synchronous active-low reset puts the whole block, including the edge detector, into a known idle state.

Top module: `piso_shreg`

## Requirements
- R1: With `rst_n` low at a rising edge of `clk`, every stage and the edge detector return to 0, so `ser_out` reads 0.
- R2: `ser_out` always shows stage 7, the highest-numbered stage.
- R3: An advance event is a rising edge of one qualifying input while the other input is low. Each event moves the register exactly one step. The step takes effect by the third rising `clk` edge after the input change.
- R4: On an advance with `mode_shift` = 0, stage i takes `par_in[i]` for every i. The first bit seen on `ser_out` after the load is therefore `par_in[7]`.
- R5: On an advance with `mode_shift` = 1, stage i takes stage i-1 for i = 1..7, and stage 0 takes `ser_in`.
- R6: While one qualifying input is held high, rising and falling edges on the other input do not move the register.
- R7: A rising edge of `tick_b` while `tick_a` is low is an advance event, just like a rising edge of `tick_a` while `tick_b` is low.
- R8: While `clr_n` is low, all stages are 0 at once, without waiting for a `clk` edge. An advance event in the same period is overridden.
- R9: When there is no advance event and `clr_n` is high, all stages keep their values, whatever `par_in`, `ser_in` and `mode_shift` do.
- R10: A falling edge of the combined clock is not an advance event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| tick_a | input | 1 | Qualifying clock input A; held high, it inhibits B |
| tick_b | input | 1 | Qualifying clock input B; held high, it inhibits A |
| mode_shift | input | 1 | 0 = parallel load, 1 = serial shift on advance |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | 8 | Parallel data; bit i goes to stage i |
| ser_out | output | 1 | Value of stage 7 |

## Verification
The assertions assume that `mode_shift`, `ser_in` and `par_in` are stable during the cycle in which the advance strobe is high. They also assume that `clr_n` changes only away from `clk` edges and never pulses low and high again between two edges. The stimulus changes every input on the falling clock edge and holds the data inputs for several cycles around each qualifying edge, so the strobe always samples settled values. Each qualifying input is held for four cycles on each side of an edge, which is more than the synchroniser latency, so no event is merged with another or lost.

// File: rtl/piso_pkg.sv
// Shared definitions for the parallel-load serial-out shift register.
// Assumes: the mode encoding below is also the encoding of the mode_shift pin.
package piso_pkg;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_SYNC  = 2;

    typedef enum logic {
        STEP_LOAD  = 1'b0,
        STEP_SHIFT = 1'b1
    } step_mode_e;
endpackage

// File: rtl/piso_edge_strobe.sv
// Combines two qualifying inputs by OR, synchronises the result to clk,
// and emits a one-cycle strobe on each rising edge of the combined clock.
// Assumes: SYNC_STAGES >= 2; the qualifying inputs are asynchronous to clk.
module piso_edge_strobe #(
    parameter int SYNC_STAGES = piso_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_a,
    input  logic tick_b,
    output logic adv
);
    localparam int LAST = SYNC_STAGES - 1;

    logic                   merged;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Combined clock: high while either qualifying input is high.
    assign merged = tick_a | tick_b;

    // Synchroniser chain and previous-value flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], merged};
            prev_q <= sync_q[LAST];
        end
    end

    // Rising edge of the synchronised combined clock.
    assign adv = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/piso_stage_chain.sv
// Storage stages of the shift register. On the advance strobe, every stage
// takes either its parallel input or its lower neighbour (stage 0 takes the
// serial input). The clear is asynchronous and wins over everything else.
// Assumes: WIDTH >= 2; data inputs are stable while adv is high.
module piso_stage_chain #(
    parameter int WIDTH = piso_pkg::DEF_WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_n,
    input  logic                adv,
    input  piso_pkg::step_mode_e mode,
    input  logic                ser_in,
    input  logic [WIDTH-1:0]    par_in,
    output logic [WIDTH-1:0]    stage_q
);
    logic [WIDTH-1:0] next_d;

    // Next value for each stage, chosen by the mode.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign next_d[i] = (mode == piso_pkg::STEP_LOAD) ? par_in[i] : ser_in;
        end else begin : g_rest
            assign next_d[i] = (mode == piso_pkg::STEP_LOAD) ? par_in[i] : stage_q[i-1];
        end
    end

    // Stage flops: async clear, sync reset, update on strobe, else hold.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q <= '0;
        end else if (!rst_n) begin
            stage_q <= '0;
        end else if (adv) begin
            stage_q <= next_d;
        end
    end
endmodule

// File: rtl/piso_shreg.sv
// Top level of the parallel-load serial-out shift register. Joins the
// qualifying-clock edge detector with the storage chain; only the last
// stage is brought out.
// Assumes: the system clock is fast enough to see every qualifying edge.
module piso_shreg #(
    parameter int WIDTH       = piso_pkg::DEF_WIDTH,
    parameter int SYNC_STAGES = piso_pkg::DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             mode_shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    localparam int MSB = WIDTH - 1;

    logic             adv;
    logic [WIDTH-1:0] stage_q;
    piso_pkg::step_mode_e mode;

    // Pin level to mode type.
    assign mode = piso_pkg::step_mode_e'(mode_shift);

    piso_edge_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_a (tick_a),
        .tick_b (tick_b),
        .adv    (adv)
    );

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .adv     (adv),
        .mode    (mode),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    // Only the last stage is visible.
    assign ser_out = stage_q[MSB];
endmodule

// File: rtl/piso_shreg_checks.sv
// Property checker for piso_shreg, attached with bind below.
// Assumes: data inputs are stable on strobe cycles; clr_n changes away from clk edges.
module piso_shreg_checks #(
    parameter int WIDTH = piso_pkg::DEF_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             adv,
    input logic             mode_shift,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stage_q
);
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);

    assert_load_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && adv && !mode_shift) |=> (!clr_n || stage_q == $past(par_in)));

    assert_shift_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && adv && mode_shift) |=>
            (!clr_n || stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (stage_q == '0));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !adv) |=> (!clr_n || stage_q == $past(stage_q)));
endmodule

bind piso_shreg piso_shreg_checks #(.WIDTH(WIDTH)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .adv        (adv),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .stage_q    (stage_q)
);

// File: tb/piso_shreg_tb.sv
// Directed bench for piso_shreg: one task per scenario, each checking itself.
module piso_shreg_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b1;
    logic         tick_a = 1'b0;
    logic         tick_b = 1'b0;
    logic         mode_shift = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;

    int           errs = 0;
    int           checks = 0;
    logic [W-1:0] exp_q = '0;

    always #4 clk = ~clk;

    piso_shreg #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n      (clr_n),
        .tick_a     (tick_a),
        .tick_b     (tick_b),
        .mode_shift (mode_shift),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .ser_out    (ser_out)
    );

    task automatic check_bit(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s: ser_out=%0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Model one advance from the requirements (R4, R5, R8).
    task automatic model_step();
        if (!clr_n) exp_q = '0;
        else if (!mode_shift) exp_q = par_in;
        else exp_q = {exp_q[W-2:0], ser_in};
    endtask

    // One event on tick_a (R3): rise, settle, fall (R10), settle.
    task automatic pulse_a(input string req);
        tick_a = 1'b1;
        model_step();
        settle(4);
        check_bit(req, ser_out, exp_q[W-1]);
        tick_a = 1'b0;
        settle(4);
        check_bit("R10", ser_out, exp_q[W-1]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        check_bit("R1", ser_out, 1'b0);
        par_in = 8'hFF;
        mode_shift = 1'b0;
        pulse_a("R4");
        rst_n = 1'b0;
        settle(1);
        rst_n = 1'b1;
        exp_q = '0;
        settle(1);
        check_bit("R1", ser_out, 1'b0);
    endtask

    task automatic t_load_shift();
        logic [W-1:0] ser_pat;
        ser_pat = 8'h5A;
        par_in = 8'hB4;
        mode_shift = 1'b0;
        pulse_a("R4");
        check_bit("R4", ser_out, 1'b1);
        mode_shift = 1'b1;
        for (int i = 0; i < 15; i++) begin
            ser_in = (i < W) ? ser_pat[W-1-i] : 1'b0;
            par_in = ~par_in;
            pulse_a("R5");
        end
    endtask

    task automatic t_inhibit();
        mode_shift = 1'b0;
        par_in = 8'h0F;
        pulse_a("R4");
        mode_shift = 1'b1;
        ser_in = 1'b1;
        tick_b = 1'b1;
        model_step();
        settle(4);
        check_bit("R7", ser_out, exp_q[W-1]);
        for (int i = 0; i < 4; i++) begin
            tick_a = 1'b1;
            settle(4);
            check_bit("R6", ser_out, exp_q[W-1]);
            tick_a = 1'b0;
            settle(4);
            check_bit("R6", ser_out, exp_q[W-1]);
        end
        tick_b = 1'b0;
        settle(4);
        check_bit("R10", ser_out, exp_q[W-1]);
        ser_in = 1'b0;
        for (int i = 0; i < W; i++) pulse_a("R6");
    endtask

    task automatic t_hold();
        mode_shift = 1'b0;
        par_in = 8'hA5;
        pulse_a("R4");
        for (int i = 0; i < 6; i++) begin
            par_in = 8'(i * 37);
            ser_in = ~ser_in;
            mode_shift = ~mode_shift;
            settle(5);
            check_bit("R9", ser_out, exp_q[W-1]);
        end
        mode_shift = 1'b1;
        ser_in = 1'b0;
        for (int i = 0; i < W; i++) pulse_a("R9");
    endtask

    task automatic t_clear();
        mode_shift = 1'b0;
        par_in = 8'hFF;
        pulse_a("R4");
        mode_shift = 1'b1;
        ser_in = 1'b1;
        pulse_a("R5");
        pulse_a("R5");
        check_bit("R8", ser_out, 1'b1);
        @(negedge clk);
        clr_n = 1'b0;
        exp_q = '0;
        #1;
        check_bit("R8", ser_out, 1'b0);
        pulse_a("R8");
        clr_n = 1'b1;
        settle(2);
        check_bit("R8", ser_out, 1'b0);
        mode_shift = 1'b0;
        par_in = 8'h80;
        pulse_a("R4");
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL R3: watchdog expired, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_load_shift();
        t_inhibit();
        t_hold();
        t_clear();
        check_bit("R2", ser_out, exp_q[W-1]);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule